// File: doc/BRIEF.md
# Selectable CPU Clock Generator

The block derives a processor cycle from a single master clock. Each processor cycle lasts a whole number of master clocks, and the generator shows that cycle as a phase signal: low in the first part of the cycle and high in the second part. It also gives a one-clock strobe on the last master clock of the cycle. A 4-bit speed code picks one of sixteen fast cycle lengths, from 2 to 17 master clocks. A fixed slow length of 14 master clocks is the same length that speed code 12 gives. Odd lengths give a low phase one clock longer than the high phase, so every ratio still has a usable phase pair.

Two inputs force the slow length. The first is a sticky override, used while configuration is being rewritten. The second is a per-cycle request, raised by address decode when the coming cycle reaches the host interface region or the slow ROM. The generator samples the speed code and both slow inputs only on the master clock edge that ends a cycle. A rate change therefore always starts a new complete cycle, and no shortened phase is ever produced. An output flag reports whether the cycle now running is a slow one. After reset the generator starts with one slow cycle.

Top module: `cpu_clkgen`

## Requirements
- R1: While reset is high, `cpu_phi2` is 0, `cpu_cyc_end` is 0 and `rate_slow` is 1. The first cycle after reset lasts 14 master clocks and has `rate_slow` at 1, whatever the inputs are.
- R2: When neither slow input is set at a boundary, the next cycle lasts `div_code + 2` master clocks. Here `div_code` is an unsigned value from 0 to 15, so the length runs from 2 to 17.
- R3: In a cycle of N master clocks, `cpu_phi2` is 0 for the first ceil(N/2) clocks and 1 for the last floor(N/2) clocks.
- R4: `cpu_cyc_end` is a single-clock pulse that is high exactly on the last master clock of every cycle. `cpu_phi2` is 1 on that clock.
- R5: When `force_slow` is 1 at a boundary, the next cycle lasts 14 master clocks and `div_code` has no effect.
- R6: When `slow_req` is 1 at a boundary, the next cycle lasts 14 master clocks whatever `div_code` is. The slowdown covers only that one cycle: a later boundary with `slow_req` at 0 goes back to the fast length.
- R7: `div_code`, `force_slow` and `slow_req` are sampled only on the master clock edge where `cpu_cyc_end` is 1. Changes at any other time do not alter the cycle in progress.
- R8: `rate_slow` is 1 for a whole cycle exactly when that cycle was started with `force_slow` or `slow_req` set. It stays constant within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Fast speed code, cycle length code+2 |
| force_slow | input | 1 | Override forcing the slow length |
| slow_req | input | 1 | Slow length request for the coming cycle |
| cpu_phi2 | output | 1 | Processor phase, high in the second part of the cycle |
| cpu_cyc_end | output | 1 | High on the last master clock of a cycle |
| rate_slow | output | 1 | The current cycle runs at the slow length |

## Verification
The bench measures the length of every cycle and the length of its high phase. The odd lengths (3, 15, 17) and the shortest length (2) are the cases most likely to be wrong. A design that rounds the split the wrong way or drops a pulse would show the wrong high count there, or a merged pair of cycles. The bench turns the per-cycle request on and off between codes 0 and 15 to show that the slowdown lasts exactly one cycle. It also changes the code and the request in the middle of a cycle. A design that sampled its inputs outside the boundary would change length early, or stretch the cycle it is in, and the bench would see a wrong length or a wrong slow flag. The force override is held while codes sweep, to show that the code is ignored.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Width of the fast speed code.
    parameter int CODE_W    = 4;
    // Cycle length for code k is k + DIV_OFS master clocks.
    parameter int DIV_OFS   = 2;
    // The slow length equals the length of this code.
    parameter int SLOW_CODE = 12;

    localparam int NUM_CODES = 1 << CODE_W;
    localparam int MAX_DIV   = NUM_CODES - 1 + DIV_OFS;
    localparam int MIN_DIV   = DIV_OFS;
    localparam int CNT_W     = $clog2(MAX_DIV + 1);
    localparam int SLOW_DIV  = SLOW_CODE + DIV_OFS;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // What picked the length of a cycle.
    typedef enum logic [1:0] {
        SRC_FAST   = 2'd0,
        SRC_FORCED = 2'd1,
        SRC_ACCESS = 2'd2,
        SRC_RESET  = 2'd3
    } rate_src_e;

    // Rate chosen for one processor cycle.
    typedef struct packed {
        cnt_t      div;
        logic      slow;
        rate_src_e src;
    } rate_sel_t;

    // Cycle position state.
    typedef struct packed {
        cnt_t      cnt;
        rate_sel_t sel;
    } cyc_state_t;

    function automatic cnt_t div_of_code(input code_t code);
        return cnt_t'(code) + cnt_t'(DIV_OFS);
    endfunction

    // Clocks of the low phase: the larger half for odd lengths.
    function automatic cnt_t low_len(input cnt_t div);
        return cnt_t'((div + cnt_t'(1)) >> 1);
    endfunction

    function automatic rate_sel_t reset_sel();
        rate_sel_t s;
        s.div  = cnt_t'(SLOW_DIV);
        s.slow = 1'b1;
        s.src  = SRC_RESET;
        return s;
    endfunction

endpackage

// File: rtl/cpu_rate_select.sv
module cpu_rate_select
    import clkgen_pkg::*;
(
    input  code_t     div_code,
    input  logic      force_slow,
    input  logic      slow_req,
    output rate_sel_t sel
);

    // The override has priority over the per-access request. Both give
    // the same length and differ only in the recorded source.
    always_comb begin
        if (force_slow) begin
            sel.div  = cnt_t'(SLOW_DIV);
            sel.slow = 1'b1;
            sel.src  = SRC_FORCED;
        end else if (slow_req) begin
            sel.div  = cnt_t'(SLOW_DIV);
            sel.slow = 1'b1;
            sel.src  = SRC_ACCESS;
        end else begin
            sel.div  = div_of_code(div_code);
            sel.slow = 1'b0;
            sel.src  = SRC_FAST;
        end
    end

endmodule

// File: rtl/cpu_cycle_timer.sv
module cpu_cycle_timer
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rate_sel_t  sel_in,
    output cyc_state_t cur,
    output cyc_state_t nxt
);

    cyc_state_t st_q;
    logic       at_end;

    // The last clock of a cycle is the only place a new rate is taken.
    assign at_end = (st_q.cnt == st_q.sel.div - cnt_t'(1));

    always_comb begin
        if (at_end) begin
            nxt.cnt = '0;
            nxt.sel = sel_in;
        end else begin
            nxt.cnt = st_q.cnt + cnt_t'(1);
            nxt.sel = st_q.sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.sel <= reset_sel();
        end else begin
            st_q <= nxt;
        end
    end

    assign cur = st_q;

endmodule

// File: rtl/cpu_phase_shaper.sv
module cpu_phase_shaper
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cyc_state_t nxt,
    output logic       phi2,
    output logic       cyc_end
);

    logic phi2_d;
    logic end_d;

    // Outputs are decoded from the next state and registered, so that
    // both reach the pins straight from flops.
    always_comb begin
        phi2_d = (nxt.cnt >= low_len(nxt.sel.div));
        end_d  = (nxt.cnt == nxt.sel.div - cnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phi2    <= 1'b0;
            cyc_end <= 1'b0;
        end else begin
            phi2    <= phi2_d;
            cyc_end <= end_d;
        end
    end

endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] div_code,
    input  logic              force_slow,
    input  logic              slow_req,
    output logic              cpu_phi2,
    output logic              cpu_cyc_end,
    output logic              rate_slow
);

    rate_sel_t  sel_w;
    cyc_state_t cur_w;
    cyc_state_t nxt_w;

    cpu_rate_select u_sel (
        .div_code   (div_code),
        .force_slow (force_slow),
        .slow_req   (slow_req),
        .sel        (sel_w)
    );

    cpu_cycle_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .sel_in (sel_w),
        .cur    (cur_w),
        .nxt    (nxt_w)
    );

    cpu_phase_shaper u_shape (
        .clk     (clk),
        .rst     (rst),
        .nxt     (nxt_w),
        .phi2    (cpu_phi2),
        .cyc_end (cpu_cyc_end)
    );

    assign rate_slow = cur_w.sel.slow;

endmodule

// File: rtl/cpu_clkgen_chk.sv
module cpu_clkgen_chk
    import clkgen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] div_code,
    input logic              force_slow,
    input logic              slow_req,
    input logic              cpu_phi2,
    input logic              cpu_cyc_end,
    input logic              rate_slow
);

    // Clocks seen since the last cycle end.
    logic [CNT_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || cpu_cyc_end) run_len <= '0;
        else                    run_len <= run_len + 1'b1;
    end

    AST_RST_OUTPUTS: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_phi2 && !cpu_cyc_end && rate_slow)); // R1

    AST_CYCLE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_len < (CNT_W+1)'(MAX_DIV)); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        cpu_cyc_end |=> !cpu_phi2); // R3

    AST_END_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        cpu_cyc_end |-> cpu_phi2); // R4

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cpu_cyc_end |=> !cpu_cyc_end); // R4

    AST_FORCE_SLOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_cyc_end && force_slow) |=> rate_slow); // R5

    AST_REQ_SLOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_cyc_end && slow_req) |=> rate_slow); // R6

    AST_FAST_NOT_SLOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_cyc_end && !slow_req && !force_slow) |=> !rate_slow); // R6

    AST_SLOW_HELD: assert property (@(posedge clk) disable iff (rst)
        !cpu_cyc_end |=> $stable(rate_slow)); // R7 R8

endmodule

bind cpu_clkgen cpu_clkgen_chk u_chk (.*);

// File: tb/cpu_clkgen_tb.sv
module cpu_clkgen_tb;
    import clkgen_pkg::*;

    typedef struct {
        int len;
        bit slow;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  div_code = 4'd0;
    logic        force_slow = 1'b0;
    logic        slow_req = 1'b0;
    logic        cpu_phi2;
    logic        cpu_cyc_end;
    logic        rate_slow;

    int   n_chk  = 0;
    int   n_fail = 0;
    exp_t q[$];
    int   len_c = 0;
    int   hi_c  = 0;

    always #4 clk = ~clk;

    cpu_clkgen u_dut (
        .clk(clk), .rst(rst), .div_code(div_code),
        .force_slow(force_slow), .slow_req(slow_req),
        .cpu_phi2(cpu_phi2), .cpu_cyc_end(cpu_cyc_end), .rate_slow(rate_slow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measures each cycle and compares it with the queue head.
    always @(negedge clk) begin
        if (rst) begin
            check(!cpu_phi2 && !cpu_cyc_end && rate_slow, "R1 reset outputs",
                  {cpu_phi2, cpu_cyc_end, rate_slow}, 3'b001);
            len_c = 1;
            hi_c  = 0;
        end else begin
            len_c++;
            if (cpu_phi2) hi_c++;
            if (q.size() > 0)
                check(rate_slow == q[0].slow, {"R8 slow flag ", q[0].tag},
                      rate_slow, q[0].slow);
            if (cpu_cyc_end) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(len_c == e.len, {"R2 cycle length ", e.tag}, len_c, e.len);
                    check(hi_c == e.len / 2, {"R3 high phase ", e.tag}, hi_c, e.len / 2);
                    check(cpu_phi2, "R4 end in high phase", cpu_phi2, 1);
                end
                len_c = 0;
                hi_c  = 0;
            end
        end
    end

    task automatic wait_end();
        forever begin
            @(negedge clk);
            if (cpu_cyc_end) break;
        end
    endtask

    // Driver: at a cycle end, sets the inputs for the next cycle and
    // queues what that cycle must look like. If wiggle is set, the inputs
    // are changed again in the middle of the cycle (R7).
    task automatic drive(input bit f, input bit r, input int c, input bit wiggle, input string tag);
        exp_t e;
        wait_end();
        force_slow = f;
        slow_req   = r;
        div_code   = 4'(c);
        e.len  = (f || r) ? 14 : c + 2;
        e.slow = f || r;
        e.tag  = tag;
        q.push_back(e);
        if (wiggle) begin
            @(negedge clk);
            div_code   = ~4'(c);
            slow_req   = ~r;
            force_slow = ~f;
        end
    endtask

    initial begin
        exp_t first;
        first.len = 14; first.slow = 1'b1; first.tag = "R1 first cycle";
        div_code = 4'd0;
        slow_req = 1'b0;
        repeat (3) @(negedge clk);
        q.push_back(first);
        rst <= 1'b0;
        // R2 R3 every fast code
        for (int c = 0; c < 16; c++) drive(0, 0, c, 0, "R2 sweep");
        for (int c = 15; c >= 0; c -= 3) drive(0, 0, c, 0, "R2 down");
        // R5 override ignores code
        for (int c = 0; c < 16; c += 5) drive(1, 0, c, 0, "R5 forced");
        drive(1, 1, 0, 0, "R5 forced with req");
        // R6 per-cycle request, back to fast at once
        drive(0, 1, 0, 0, "R6 req code0");
        drive(0, 0, 0, 0, "R6 back fast");
        drive(0, 1, 15, 0, "R6 req code15");
        drive(0, 0, 15, 0, "R6 back 17");
        drive(0, 1, 1, 0, "R6 req");
        drive(0, 1, 1, 0, "R6 req again");
        drive(0, 0, 1, 0, "R6 back 3");
        // R7 mid-cycle changes have no effect
        drive(0, 0, 3, 1, "R7 wiggle fast");
        drive(0, 0, 15, 1, "R7 wiggle 17");
        drive(0, 1, 6, 1, "R7 wiggle req");
        drive(1, 0, 9, 1, "R7 wiggle force");
        drive(0, 0, 0, 0, "R7 after wiggle");
        drive(0, 0, 12, 0, "R8 code12 fast");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule